// File: doc/BRIEF.md
# Cascaded Boxcar and Decimation Filter

This block is a streaming low-pass filter for signed 16-bit samples. Each accepted sample passes through two identical moving-average stages in series. Each stage averages the most recent 2^B values it has seen, so the pair has a triangular impulse response. A third stage then sums 2^D consecutive results of the second stage. It emits one result per 2^D inputs and then starts a new block.

Each result has two words. The primary word is the block average, rounded toward minus infinity, at the same scale as the input. The extension word holds the fractional bits that the averaging recovers. These bits are packed from bit 15 downward, so a host can join the two words into one wider fixed-point value. A change to either setting empties the filter, and filtering restarts from a clean state with the new settings.

Top module: `bartlett_decim_filter`

## Requirements
- R1: While reset is asserted and after it is released with no input, `out_valid` is 0 and `out_main` and `out_ext` are 0.
- R2: Each averaging stage outputs floor(S / 2^B), where S is the sum of the last 2^B values the stage accepted since the last flush, counting missing history as zero.
- R3: The two averaging stages are in series (triangular response). With B = 0, both stages pass each sample through unchanged.
- R4: The final stage emits exactly one result per 2^D second-stage outputs, with `out_main` = floor(sum / 2^D) as a signed 16-bit value. With D >= 1, no two results come on consecutive cycles.
- R5: `out_ext` carries the low D bits of the block sum in bits 15 down to 16-D. All its lower bits are zero, and it is all zero when D = 0.
- R6: With D = 0, a sample accepted on a clock edge produces `out_valid` high right after the second following rising edge.
- R7: An `avg_log2` value of 7 acts as 6, and a `dec_log2` value above 16 acts as 16.
- R8: Any change of the effective settings discards all history, the running sums and the partial decimation block. No result is emitted on the cycle after the change.
- R9: A block of 65536 full-scale negative samples averages to -32768 with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 16 | Signed input sample |
| avg_log2 | input | 3 | B: log2 of the tap count of each averaging stage |
| dec_log2 | input | 5 | D: log2 of the decimation factor |
| out_valid | output | 1 | Result strobe |
| out_main | output | 16 | Signed block average |
| out_ext | output | 16 | Extra resolution bits, MSB-justified |

## Verification
The assertions check these rules on every cycle:
- pass-through with B = 0,
- the bound on history fill,
- spacing between results when D >= 1,
- zero fill of the unused extension bits,
- silence on the cycle after a settings change.

The rest needs the bench's scenarios:
- the arithmetic values of the averages and the extension word,
- the triangular shape built from partial history,
- clamping of out-of-range settings,
- the result count per block,
- freedom from overflow over a full 65536-sample block.

// File: rtl/bdf_pkg.sv
package bdf_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int AVG_MAX   = 6;
  localparam int DEC_MAX   = 16;
  localparam int AVG_SEL_W = 3;
  localparam int DEC_SEL_W = 5;
endpackage

// File: rtl/bdf_boxcar.sv
module bdf_boxcar #(
  parameter int DATA_W   = 16,
  parameter int LOG2_MAX = 6,
  parameter int SEL_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [SEL_W-1:0]         sel,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data
);
  localparam int DEPTH = 1 << LOG2_MAX;
  localparam int PTR_W = LOG2_MAX;
  localparam int CNT_W = LOG2_MAX + 1;
  localparam int SUM_W = DATA_W + LOG2_MAX;

  logic signed [DATA_W-1:0] hist_q [DEPTH];
  logic signed [SUM_W-1:0]  sum_q, sum_base, sum_new, sum_d, avg_full;
  logic [PTR_W-1:0]         ptr_q, ptr_base, ptr_d, rd_idx;
  logic [CNT_W-1:0]         fill_q, fill_base, fill_d, taps;
  logic signed [DATA_W-1:0] oldest, out_data_d;
  logic                     out_valid_d;

  // next-state logic
  always_comb begin
    taps      = CNT_W'(1) << sel;
    sum_base  = flush ? '0 : sum_q;
    ptr_base  = flush ? '0 : ptr_q;
    fill_base = flush ? '0 : fill_q;
    rd_idx    = ptr_base - taps[PTR_W-1:0];
    oldest    = (fill_base >= taps) ? hist_q[rd_idx] : '0;
    sum_new   = sum_base + SUM_W'(in_data) - SUM_W'(oldest);
    avg_full  = sum_new >>> sel;
    if (in_valid) begin
      sum_d  = sum_new;
      ptr_d  = ptr_base + PTR_W'(1);
      fill_d = (fill_base == CNT_W'(DEPTH)) ? fill_base : fill_base + CNT_W'(1);
    end else begin
      sum_d  = sum_base;
      ptr_d  = ptr_base;
      fill_d = fill_base;
    end
    out_valid_d = in_valid;
    out_data_d  = in_valid ? avg_full[DATA_W-1:0] : out_data;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q     <= '0;
      ptr_q     <= '0;
      fill_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      sum_q     <= sum_d;
      ptr_q     <= ptr_d;
      fill_q    <= fill_d;
      out_valid <= out_valid_d;
      out_data  <= out_data_d;
    end
  end

  // history storage, no reset; unwritten slots are masked by the fill count
  always_ff @(posedge clk) begin
    if (in_valid) begin
      hist_q[ptr_base] <= in_data;
    end
  end

  assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CNT_W'(DEPTH));

  assert_pass_through_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel == '0) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: rtl/bdf_decim.sv
module bdf_decim #(
  parameter int DATA_W   = 16,
  parameter int LOG2_MAX = 16,
  parameter int SEL_W    = 5,
  parameter int ACC_W    = DATA_W + LOG2_MAX
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic [SEL_W-1:0]         sel,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_main,
  output logic [DATA_W-1:0]        out_ext
);
  localparam int CNT_W = LOG2_MAX + 1;
  localparam int SH_W  = SEL_W + 1;

  logic signed [ACC_W-1:0]  acc_q, acc_base, acc_new, acc_d, shifted;
  logic [CNT_W-1:0]         cnt_q, cnt_base, cnt_new, cnt_d, target;
  logic [2*DATA_W-1:0]      ext_wide;
  logic [SH_W-1:0]          ext_sh;
  logic                     hit;
  logic [DATA_W-1:0]        main_d, ext_d;

  always_comb begin
    target   = CNT_W'(1) << sel;
    acc_base = flush ? '0 : acc_q;
    cnt_base = flush ? '0 : cnt_q;
    acc_new  = acc_base + ACC_W'(in_data);
    cnt_new  = cnt_base + CNT_W'(1);
    hit      = in_valid && (cnt_new == target);
    shifted  = acc_new >>> sel;
    ext_sh   = SH_W'(DATA_W) - {1'b0, sel};
    ext_wide = {{DATA_W{1'b0}}, acc_new[DATA_W-1:0]} << ext_sh;
    if (!in_valid) begin
      acc_d = acc_base;
      cnt_d = cnt_base;
    end else if (hit) begin
      acc_d = '0;
      cnt_d = '0;
    end else begin
      acc_d = acc_new;
      cnt_d = cnt_new;
    end
    main_d = hit ? shifted[DATA_W-1:0] : out_main;
    ext_d  = hit ? ext_wide[DATA_W-1:0] : out_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
      out_main  <= '0;
      out_ext   <= '0;
    end else begin
      acc_q     <= acc_d;
      cnt_q     <= cnt_d;
      out_valid <= hit;
      out_main  <= main_d;
      out_ext   <= ext_d;
    end
  end

  assert_decim_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sel != '0) |=> !out_valid);

  assert_ext_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_ext & (16'hFFFF >> $past(sel))) == '0));
endmodule

// File: rtl/bartlett_decim_filter.sv
module bartlett_decim_filter
  import bdf_pkg::*;
#(
  parameter int DATA_W = SAMPLE_W,
  parameter int B_MAX  = AVG_MAX,
  parameter int D_MAX  = DEC_MAX,
  parameter int B_W    = AVG_SEL_W,
  parameter int D_W    = DEC_SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [B_W-1:0]    avg_log2,
  input  logic [D_W-1:0]    dec_log2,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_main,
  output logic [DATA_W-1:0] out_ext
);
  localparam int NSTAGE = 2;

  logic [B_W-1:0]    b_eff, b_q;
  logic [D_W-1:0]    d_eff, d_q;
  logic              flush;
  logic                     stg_v [NSTAGE+1];
  logic signed [DATA_W-1:0] stg_d [NSTAGE+1];

  always_comb begin
    b_eff = (avg_log2 > B_W'(B_MAX)) ? B_W'(B_MAX) : avg_log2;
    d_eff = (dec_log2 > D_W'(D_MAX)) ? D_W'(D_MAX) : dec_log2;
    flush = (b_eff != b_q) || (d_eff != d_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_q <= '0;
      d_q <= '0;
    end else begin
      b_q <= b_eff;
      d_q <= d_eff;
    end
  end

  assign stg_v[0] = in_valid;
  assign stg_d[0] = $signed(in_data);

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    logic v_in;
    // the first stage takes the live sample; later stages drop data in flight at a flush
    if (g == 0) begin : g_head
      assign v_in = stg_v[g];
    end else begin : g_tail
      assign v_in = stg_v[g] && !flush;
    end
    bdf_boxcar #(.DATA_W(DATA_W), .LOG2_MAX(B_MAX), .SEL_W(B_W)) i_box (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .sel      (b_eff),
      .in_valid (v_in),
      .in_data  (stg_d[g]),
      .out_valid(stg_v[g+1]),
      .out_data (stg_d[g+1])
    );
  end

  bdf_decim #(.DATA_W(DATA_W), .LOG2_MAX(D_MAX), .SEL_W(D_W)) i_decim (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .sel      (d_eff),
    .in_valid (stg_v[NSTAGE] && !flush),
    .in_data  (stg_d[NSTAGE]),
    .out_valid(out_valid),
    .out_main (out_main),
    .out_ext  (out_ext)
  );

  assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);
endmodule

// File: tb/test_bartlett_decim_filter.sv
module test_bartlett_decim_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_data;
  logic [2:0]  avg_log2;
  logic [4:0]  dec_log2;
  logic        out_valid;
  logic [15:0] out_main, out_ext;

  int checks = 0;
  int errors = 0;
  string cur_req = "R2";

  int h1 [64];
  int h2 [64];
  int n1, n2, mb, md, dcnt;
  longint dacc;
  logic [31:0] exp_q [$];

  always #10 clk = ~clk;

  bartlett_decim_filter i_bartlett_decim_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .avg_log2(avg_log2), .dec_log2(dec_log2),
    .out_valid(out_valid), .out_main(out_main), .out_ext(out_ext)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int box_avg(input int hist[64], input int n, input int b);
    int s = 0;
    for (int i = 0; i < (1 << b); i++) if (i < n) s += hist[i];
    return s >>> b;
  endfunction

  task automatic model_reset(input int b, input int d);
    for (int i = 0; i < 64; i++) begin h1[i] = 0; h2[i] = 0; end
    n1 = 0; n2 = 0; dacc = 0; dcnt = 0; mb = b; md = d;
  endtask

  task automatic model_push(input int x);
    int y1, y2, em, ee;
    longint mask;
    for (int i = 63; i > 0; i--) h1[i] = h1[i-1];
    h1[0] = x; if (n1 < 64) n1++;
    y1 = box_avg(h1, n1, mb);
    for (int i = 63; i > 0; i--) h2[i] = h2[i-1];
    h2[0] = y1; if (n2 < 64) n2++;
    y2 = box_avg(h2, n2, mb);
    dacc += longint'(y2);
    dcnt++;
    if (dcnt == (1 << md)) begin
      mask = (longint'(1) << md) - 1;
      em = int'((dacc >>> md) & 64'hFFFF);
      ee = int'(((dacc & mask) << (16 - md)) & 64'hFFFF);
      exp_q.push_back({em[15:0], ee[15:0]});
      dacc = 0; dcnt = 0;
    end
  endtask

  task automatic send(input logic [15:0] x, input int gap);
    in_valid = 1'b1;
    in_data  = x;
    model_push(int'($signed(x)));
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic set_cfg(input int b, input int d);
    repeat (4) @(negedge clk);
    avg_log2 = 3'(b);
    dec_log2 = 5'(d);
    @(negedge clk);
    model_reset((b > 6) ? 6 : b, (d > 16) ? 16 : d);
  endtask

  // output monitor, sampling on the falling edge
  always @(negedge clk) begin
    logic [31:0] e;
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected result", int'($signed(out_main)), 0);
      end else begin
        e = exp_q.pop_front();
        chk(out_main == e[31:16], cur_req, "out_main", int'($signed(out_main)), int'($signed(e[31:16])));
        chk(out_ext == e[15:0], (cur_req == "R2") ? "R5" : cur_req, "out_ext", int'(out_ext), int'(e[15:0]));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] r;
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; avg_log2 = '0; dec_log2 = '0;
    model_reset(0, 0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(out_main == 16'd0 && out_ext == 16'd0, "R1", "words in reset", int'(out_main), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid idle after reset", int'(out_valid), 0);

    // R6 and R3: latency and pass-through with B = 0, D = 0
    cur_req = "R3";
    in_valid = 1'b1; in_data = 16'd1234; model_push(1234);
    @(negedge clk); in_valid = 1'b0;
    chk(out_valid == 1'b0, "R6", "valid one cycle after accept", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "valid two cycles after accept", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R6", "valid after second following edge", int'(out_valid), 1);
    chk(out_main == 16'd1234, "R3", "pass-through value", int'(out_main), 1234);
    for (int i = 0; i < 20; i++) begin r = 16'($urandom); send(r, 0); end

    // R2, R4, R5: random settings with random gaps
    for (int k = 0; k < 8; k++) begin
      cur_req = "R2";
      set_cfg(int'($urandom % 7), int'($urandom % 6));
      for (int i = 0; i < 300; i++) begin
        case ($urandom % 8)
          0: r = 16'h7FFF;
          1: r = 16'h8000;
          default: r = 16'($urandom);
        endcase
        send(r, int'($urandom % 3));
      end
    end

    // R4: D = 4 with constant input, one result per 16 samples
    cur_req = "R4";
    set_cfg(2, 4);
    for (int i = 0; i < 64; i++) send(16'd300, 0);

    // R8: a settings change drops the partial block and history
    cur_req = "R8";
    set_cfg(2, 3);
    for (int i = 0; i < 13; i++) send(16'($urandom), 0);
    set_cfg(1, 3);
    for (int i = 0; i < 16; i++) send(16'($urandom), 0);

    // R7: B = 7 behaves as 6
    cur_req = "R7";
    set_cfg(7, 0);
    for (int i = 0; i < 100; i++) send(16'($urandom), 0);

    // R7 and R9: D = 20 behaves as 16; a full-scale negative block does not overflow
    cur_req = "R9";
    set_cfg(7, 20);
    for (int i = 0; i < 65536; i++) send(16'h8000, 0);

    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "results still expected", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule